// File: doc/BRIEF.md
# Watchdog Fail-Safe Mode Controller

This block is the digital mode manager of a two-channel smart output switch. It keeps one of four modes (Sleep, Normal, Fault, Fail-safe) and drives the enables of both output channels. The mode follows the wake and reset pins, the per-channel fault flags and a supply-valid flag. A watchdog is serviced from the serial command path: a decoded frame strobe with its data word arrives from an external shifter, and a change in one bit of that word from one frame to the next counts as a kick.

When the watchdog runs out, the controller latches into Fail-safe. In that mode a 2-bit strap code sets the channel pattern and the direct inputs have no effect. The controller pulses a request so that the overcurrent settings reload their defaults. It stays in Fail-safe until the wake and reset pins fall together, or until the strap is set to its grounded code. The grounded code also turns watchdog supervision off.

When the supply-valid flag is low, the stored settings are cleared and the channels follow the direct input pins. The wake pin, the reset pin and the strap code pass through two-flop synchronizers. Every decision uses the synchronized values.

Top module: `wfs_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards, until a wake condition, `mode_o` is 0 (Sleep), `chan_en` is 00 and `failsafe_flag` is 0. Mode codes: 0 Sleep, 1 Normal, 2 Fault, 3 Fail-safe.
- R2: Outside Fail-safe, with the supply valid, both `wake_pin` and `run_pin` low put the block into Sleep. In Sleep both enables are 0 whatever `direct_in` is, and the stored channel on-bits and the stored watchdog bit are cleared to 0.
- R3: Sleep is left when `wake_pin` is high or `run_pin` rises. The block goes to Normal when no bit of `chan_fault` is set, and to Fault otherwise.
- R4: In Normal, each channel enable is the OR of its stored on-bit and its `direct_in` bit. On-bits are `frame_data[1:0]` (bit 0 is channel 0), stored on every `frame_stb` outside Sleep.
- R5: In Fault, a channel whose `chan_fault` bit is set is off. A channel without a fault keeps its commanded state. When all faults clear, the mode returns to Normal.
- R6: A frame whose bit 7 differs from bit 7 of the previous frame reloads the watchdog. The timeout is `TO_BASE << wd_period` ticks, and one tick is `TICK_DIV` clocks. A frame with an unchanged bit 7 is not a kick. On expiry the mode becomes 3 and `failsafe_flag` is 1.
- R7: In Fail-safe the enables follow the synchronized strap code and ignore `direct_in` and the faults. Strap codes: 01 gives both channels off, 10 gives both on, 11 gives channel 0 on and channel 1 off.
- R8: Fail-safe is left to Sleep only when `wake_pin` and `run_pin` go from both high to both low on the same synchronized edge. Lowering them one after the other leaves the block in Fail-safe.
- R9: Strap code 00 (grounded) takes the block out of Fail-safe (to Normal or Fault if a pin is high). While the code is 00 the watchdog never triggers Fail-safe.
- R10: `ocp_reload` is high for exactly one clock, in the first cycle in which `mode_o` is 3, on every entry into Fail-safe.
- R11: With `supply_ok` low, `chan_en` equals `direct_in`, the mode goes to Sleep and the stored settings are cleared.
- R12: Stored channel on-bits survive Fail-safe. After a strap-00 exit with a pin high, the enables again reflect the on-bits written before the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_pin | input | 1 | Wake pin, asynchronous |
| run_pin | input | 1 | Reset/enable pin, asynchronous |
| strap_code | input | 2 | Fail-safe strap code, asynchronous |
| chan_fault | input | 2 | Per-channel fault flags |
| supply_ok | input | 1 | Logic supply valid |
| direct_in | input | 2 | Direct channel input pins |
| frame_stb | input | 1 | One-cycle strobe for a decoded serial frame |
| frame_data | input | 8 | Frame data word (bit 7 watchdog, bits 1:0 on-bits) |
| wd_period | input | 2 | Programmed watchdog period select |
| chan_en | output | 2 | Channel enables |
| mode_o | output | 2 | Current mode code |
| failsafe_flag | output | 1 | High while in Fail-safe |
| ocp_reload | output | 1 | One-cycle request to restore default overcurrent settings |

## Verification
The hardest state to reach from the ports is a Fail-safe exit that must be told apart from a look-alike. The pins fall together in one case. In the other, they fall one at a time and end in the same levels, which must not release the block. To reach this, the bench starves the watchdog with frames that carry an unchanged bit 7 until the latch sets. It then drops the pins in sequence, raises both, and drops them with one assignment, checking the mode after each step. A second timeout is followed by a strap-00 release, which shows that the on-bits written before the expiry still drive the channels. It also shows that the watchdog then stays quiet past several timeout periods.

// File: rtl/wfs_pkg.sv
// Shared types and constants for the fail-safe mode controller.
// Assumes exactly two output channels; the strap decode depends on it.
package wfs_pkg;

    localparam int CH_N = 2;

    typedef enum logic [1:0] {
        MD_SLEEP    = 2'd0,
        MD_NORMAL   = 2'd1,
        MD_FAULT    = 2'd2,
        MD_FAILSAFE = 2'd3
    } mode_t;

    // Strap code meanings
    localparam logic [1:0] STRAP_GND      = 2'b00;
    localparam logic [1:0] STRAP_BOTH_OFF = 2'b01;
    localparam logic [1:0] STRAP_BOTH_ON  = 2'b10;
    localparam logic [1:0] STRAP_CH0_ONLY = 2'b11;

endpackage

// File: rtl/wfs_sync.sv
// Two-flop synchronizer for a group of asynchronous pins.
// Assumes that each bit is independent; no bus coherence is implied.
module wfs_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two register stages per bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/wfs_watchdog.sv
// Watchdog timeout counter. A free-running prescaler makes a tick every
// TICK_DIV clocks. The down-counter loads TO_BASE << period and counts ticks.
// Assumes the caller holds 'active' low in every mode where supervision is off,
// which also keeps the counter at its reload value.
module wfs_watchdog #(
    parameter int TICK_DIV = 8,
    parameter int TO_BASE  = 8,
    parameter int PER_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             kick,
    input  logic [PER_W-1:0] period,
    output logic             expired
);
    localparam int MAX_SHIFT = (1 << PER_W) - 1;
    localparam int MAX_CNT   = TO_BASE * (1 << MAX_SHIFT);
    localparam int CNT_W     = $clog2(MAX_CNT + 1);
    localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign tick  = (pre_cnt == PRE_W'(TICK_DIV - 1));
    assign limit = CNT_W'(TO_BASE) << period;

    // Prescaler: wraps every TICK_DIV clocks
    always_ff @(posedge clk) begin
        if (!rst_n || tick) pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
    end

    // Timeout counter: reload while idle or on a kick, else count ticks down
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= limit;
        else if (!active || kick)      cnt <= limit;
        else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = active && (cnt == '0);

    // R6: a kick always pushes expiry at least one cycle out
    p_kick_defers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && kick |=> !expired);

    // R6: without a kick the remaining time never grows while supervised
    p_count_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) && !$past(kick) |-> cnt <= $past(cnt));
endmodule

// File: rtl/wfs_mode_fsm.sv
// Four-mode controller. It takes the synchronized wake/run pins, the strap code,
// the fault flags, the supply flag and the watchdog expiry, and keeps the
// latched Fail-safe state. It also makes the overcurrent-default reload pulse.
// Assumes that all pin inputs are already synchronized to clk.
module wfs_mode_fsm
    import wfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wake_s,
    input  logic            run_s,
    input  logic [1:0]      strap_s,
    input  logic [CH_N-1:0] fault,
    input  logic            supply_ok,
    input  logic            wd_expired,
    output mode_t           mode,
    output logic            ocp_reload
);
    logic  wake_d, run_d;
    logic  both_fell, run_rose, pins_low, strap_gnd;
    mode_t awake_mode, nxt;

    // One more delay on the synchronized pins, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_d <= 1'b0;
            run_d  <= 1'b0;
        end else begin
            wake_d <= wake_s;
            run_d  <= run_s;
        end
    end

    assign both_fell  = wake_d && run_d && !wake_s && !run_s;
    assign run_rose   = run_s && !run_d;
    assign pins_low   = !wake_s && !run_s;
    assign strap_gnd  = (strap_s == STRAP_GND);
    assign awake_mode = (|fault) ? MD_FAULT : MD_NORMAL;

    // Next-mode selection in priority order
    always_comb begin
        nxt = mode;
        if (!supply_ok) begin
            nxt = MD_SLEEP;
        end else if (mode == MD_FAILSAFE) begin
            if (both_fell)      nxt = MD_SLEEP;
            else if (strap_gnd) nxt = pins_low ? MD_SLEEP : awake_mode;
        end else if (pins_low) begin
            nxt = MD_SLEEP;
        end else if (mode == MD_SLEEP) begin
            if (wake_s || run_rose) nxt = awake_mode;
        end else if (wd_expired && !strap_gnd) begin
            nxt = MD_FAILSAFE;
        end else begin
            nxt = awake_mode;
        end
    end

    // Mode register and the entry pulse for the overcurrent defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MD_SLEEP;
            ocp_reload <= 1'b0;
        end else begin
            mode       <= nxt;
            ocp_reload <= (nxt == MD_FAILSAFE) && (mode != MD_FAILSAFE);
        end
    end

    // R8: Fail-safe is only left through a defined exit
    p_fs_exit_only_defined_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode) == MD_FAILSAFE && mode != MD_FAILSAFE
        |-> $past(both_fell) || $past(strap_gnd) || !$past(supply_ok));

    // R9: a grounded strap never leaves the block in Fail-safe
    p_gnd_strap_blocks_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strap_gnd |=> mode != MD_FAILSAFE);

    // R10: the reload pulse marks the first Fail-safe cycle only
    p_reload_on_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_reload |-> mode == MD_FAILSAFE && $past(mode) != MD_FAILSAFE);

    // R2: both pins low outside Fail-safe leads to Sleep
    p_pins_low_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pins_low && mode != MD_FAILSAFE |=> mode == MD_SLEEP);
endmodule

// File: rtl/wfs_out_mux.sv
// Channel enable selection. Per channel, and in priority order: direct pins
// when the supply is lost, then the strap pattern in Fail-safe, then off in
// Sleep, and otherwise the commanded state masked by that channel's fault.
// Assumes the mode input comes from a register and the strap code is synchronized.
module wfs_out_mux
    import wfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  mode_t           mode,
    input  logic [1:0]      strap_s,
    input  logic            supply_ok,
    input  logic [CH_N-1:0] direct_in,
    input  logic [CH_N-1:0] cmd_on,
    input  logic [CH_N-1:0] fault,
    output logic [CH_N-1:0] chan_en
);
    logic [CH_N-1:0] fs_pattern;

    // Strap decode into the Fail-safe channel pattern
    always_comb begin
        case (strap_s)
            STRAP_BOTH_ON:  fs_pattern = 2'b11;
            STRAP_CH0_ONLY: fs_pattern = 2'b01;
            default:        fs_pattern = 2'b00;
        endcase
    end

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        // Per-channel enable select
        always_comb begin
            if (!supply_ok)                chan_en[ch] = direct_in[ch];
            else if (mode == MD_FAILSAFE)  chan_en[ch] = fs_pattern[ch];
            else if (mode == MD_SLEEP)     chan_en[ch] = 1'b0;
            else                           chan_en[ch] = (cmd_on[ch] | direct_in[ch]) & ~fault[ch];
        end
    end

    // R2: Sleep keeps both channels off while the supply is valid
    p_sleep_outputs_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok && mode == MD_SLEEP |-> chan_en == '0);

    // R5: a faulted channel is never on in an awake mode
    p_fault_channel_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok && (mode == MD_NORMAL || mode == MD_FAULT) |-> (chan_en & fault) == '0);

    // R7: in Fail-safe the enables do not move while the strap is steady
    p_fs_ignores_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok && $past(supply_ok) && mode == MD_FAILSAFE && $past(mode) == MD_FAILSAFE
        && $stable(strap_s) |-> $stable(chan_en));
endmodule

// File: rtl/wfs_ctrl.sv
// Top of the fail-safe mode controller. It synchronizes the pins, keeps the
// stored channel on-bits and the last watchdog bit, detects kicks, and ties
// together the watchdog, the mode machine and the output select.
// Assumes frame_stb/frame_data come from a decoder already in the clk domain.
module wfs_ctrl
    import wfs_pkg::*;
#(
    parameter int FRAME_W  = 8,
    parameter int WD_BIT   = 7,
    parameter int PER_W    = 2,
    parameter int TICK_DIV = 8,
    parameter int TO_BASE  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_pin,
    input  logic               run_pin,
    input  logic [1:0]         strap_code,
    input  logic [1:0]         chan_fault,
    input  logic               supply_ok,
    input  logic [1:0]         direct_in,
    input  logic               frame_stb,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic [PER_W-1:0]   wd_period,
    output logic [1:0]         chan_en,
    output logic [1:0]         mode_o,
    output logic               failsafe_flag,
    output logic               ocp_reload
);
    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] pins_s;
    logic              wake_s, run_s;
    logic [1:0]        strap_s;
    mode_t             mode;
    logic [CH_N-1:0]   cmd_on;
    logic              last_wd;
    logic              clear_regs, accept, kick, wd_active, wd_expired;

    wfs_sync #(.W(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({strap_code, run_pin, wake_pin}),
        .sync_out (pins_s)
    );

    assign wake_s  = pins_s[0];
    assign run_s   = pins_s[1];
    assign strap_s = pins_s[3:2];

    assign clear_regs = !supply_ok || (mode == MD_SLEEP);
    assign accept     = frame_stb && !clear_regs;
    assign kick       = accept && (frame_data[WD_BIT] != last_wd);
    assign wd_active  = supply_ok && (mode == MD_NORMAL || mode == MD_FAULT)
                        && (strap_s != STRAP_GND);

    // Stored settings: cleared in Sleep or without supply, kept in Fail-safe
    always_ff @(posedge clk) begin
        if (!rst_n || clear_regs) begin
            cmd_on  <= '0;
            last_wd <= 1'b0;
        end else if (accept) begin
            cmd_on  <= frame_data[CH_N-1:0];
            last_wd <= frame_data[WD_BIT];
        end
    end

    wfs_watchdog #(
        .TICK_DIV (TICK_DIV),
        .TO_BASE  (TO_BASE),
        .PER_W    (PER_W)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wd_active),
        .kick    (kick),
        .period  (wd_period),
        .expired (wd_expired)
    );

    wfs_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_s     (wake_s),
        .run_s      (run_s),
        .strap_s    (strap_s),
        .fault      (chan_fault),
        .supply_ok  (supply_ok),
        .wd_expired (wd_expired),
        .mode       (mode),
        .ocp_reload (ocp_reload)
    );

    wfs_out_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .strap_s   (strap_s),
        .supply_ok (supply_ok),
        .direct_in (direct_in),
        .cmd_on    (cmd_on),
        .fault     (chan_fault),
        .chan_en   (chan_en)
    );

    assign mode_o        = mode;
    assign failsafe_flag = (mode == MD_FAILSAFE);

    // R11: supply loss clears the stored on-bits on the next edge
    p_supply_loss_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> cmd_on == '0);
endmodule

// File: tb/wfs_ctrl_bench.sv
// Scoreboard bench: the driver pushes expected port values into a queue, and
// a monitor at the falling edge pops and compares them.
module wfs_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_pin = 1'b0, run_pin = 1'b0;
    logic [1:0] strap_code = 2'b10;
    logic [1:0] chan_fault = 2'b00;
    logic       supply_ok = 1'b1;
    logic [1:0] direct_in = 2'b00;
    logic       frame_stb = 1'b0;
    logic [7:0] frame_data = 8'h00;
    logic [1:0] wd_period = 2'd3;
    logic [1:0] chan_en, mode_o;
    logic       failsafe_flag, ocp_reload;

    int  n_checks = 0, n_fail = 0, ocp_high = 0;
    bit  done = 1'b0;
    logic wd_bit = 1'b0;

    typedef struct {
        logic [1:0] en;
        logic [1:0] md;
        logic       fl;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    wfs_ctrl u_wfs_ctrl (
        .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .run_pin(run_pin),
        .strap_code(strap_code), .chan_fault(chan_fault), .supply_ok(supply_ok),
        .direct_in(direct_in), .frame_stb(frame_stb), .frame_data(frame_data),
        .wd_period(wd_period), .chan_en(chan_en), .mode_o(mode_o),
        .failsafe_flag(failsafe_flag), .ocp_reload(ocp_reload)
    );

    // Monitor: compare every queued expectation at the next falling edge
    always @(negedge clk) begin
        if (ocp_reload) ocp_high++;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (chan_en !== e.en || mode_o !== e.md || failsafe_flag !== e.fl) begin
                n_fail++;
                $display("FAIL %s: en=%b mode=%0d flag=%b expected en=%b mode=%0d flag=%b",
                         e.tag, chan_en, mode_o, failsafe_flag, e.en, e.md, e.fl);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [1:0] en, input logic [1:0] md,
                             input logic fl, input string tag);
        exp_t e;
        e.en = en; e.md = md; e.fl = fl; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic check_val(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] cmd, input bit toggle);
        if (toggle) wd_bit = ~wd_bit;
        @(posedge clk); #1;
        frame_stb  = 1'b1;
        frame_data = {wd_bit, 5'b0, cmd};
        @(posedge clk); #1;
        frame_stb  = 1'b0;
    endtask

    // Watchdog of the bench itself
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: bench hung, got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        cyc(4);
        expect_st(2'b00, 2'd0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd0, 1'b0, "R1 after reset");

        // R3: wake pin leaves Sleep into Normal
        wake_pin = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd1, 1'b0, "R3 wake to Normal");

        // R4: on-bits ORed with direct inputs
        send(2'b01, 1'b1);
        cyc(1);
        expect_st(2'b01, 2'd1, 1'b0, "R4 on-bit ch0");
        direct_in = 2'b10;
        cyc(1);
        expect_st(2'b11, 2'd1, 1'b0, "R4 direct ch1 OR");

        // R5: fault masks only the faulted channel
        chan_fault = 2'b01;
        cyc(3);
        expect_st(2'b10, 2'd2, 1'b0, "R5 ch0 fault");
        direct_in = 2'b00;
        send(2'b11, 1'b1);
        cyc(1);
        expect_st(2'b10, 2'd2, 1'b0, "R5 ch1 keeps command");
        chan_fault = 2'b00;
        cyc(3);
        expect_st(2'b11, 2'd1, 1'b0, "R5 faults cleared");

        // R2: both pins low gives Sleep and clears settings
        wake_pin  = 1'b0;
        direct_in = 2'b11;
        cyc(4);
        expect_st(2'b00, 2'd0, 1'b0, "R2 sleep outputs off");
        wd_bit    = 1'b0;
        direct_in = 2'b00;
        run_pin   = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd1, 1'b0, "R3 run rise, R2 on-bits cleared");

        // R3: waking with a fault present enters Fault
        run_pin = 1'b0;
        cyc(4);
        expect_st(2'b00, 2'd0, 1'b0, "R2 sleep again");
        chan_fault = 2'b10;
        wake_pin   = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd2, 1'b0, "R3 wake into Fault");
        chan_fault = 2'b00;
        run_pin    = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd1, 1'b0, "R5 back to Normal");

        // R6: timeout 8 ticks x 8 clocks; unchanged bit 7 is not a kick
        wd_period = 2'd0;
        send(2'b00, 1'b1);
        cyc(10);
        send(2'b00, 1'b0);
        cyc(12);
        send(2'b00, 1'b0);
        cyc(12);
        expect_st(2'b00, 2'd1, 1'b0, "R6 before timeout");
        cyc(50);
        expect_st(2'b11, 2'd3, 1'b1, "R6 expiry, R7 strap 10 both on");
        check_val(ocp_high, 1, "R10 one reload cycle");

        // R7: strap patterns, direct inputs ignored
        strap_code = 2'b01;
        cyc(3);
        expect_st(2'b00, 2'd3, 1'b1, "R7 strap 01 both off");
        strap_code = 2'b11;
        direct_in  = 2'b11;
        chan_fault = 2'b01;
        cyc(3);
        expect_st(2'b01, 2'd3, 1'b1, "R7 strap 11 ch0 only");
        direct_in  = 2'b00;
        chan_fault = 2'b00;

        // R8: pins falling one after the other do not release
        wake_pin = 1'b0;
        cyc(4);
        run_pin = 1'b0;
        cyc(4);
        expect_st(2'b01, 2'd3, 1'b1, "R8 sequential fall holds");
        wake_pin = 1'b1;
        run_pin  = 1'b1;
        cyc(4);
        expect_st(2'b01, 2'd3, 1'b1, "R8 pins high holds");
        wake_pin = 1'b0;
        run_pin  = 1'b0;
        cyc(4);
        expect_st(2'b00, 2'd0, 1'b0, "R8 simultaneous fall exits");
        wd_bit = 1'b0;

        // R12 and R9: second timeout, then release by grounded strap
        wake_pin = 1'b1;
        cyc(4);
        expect_st(2'b00, 2'd1, 1'b0, "R3 wake after exit");
        send(2'b10, 1'b1);
        cyc(90);
        expect_st(2'b01, 2'd3, 1'b1, "R6 second expiry");
        check_val(ocp_high, 2, "R10 second reload cycle");
        strap_code = 2'b00;
        cyc(4);
        expect_st(2'b10, 2'd1, 1'b0, "R9 ground exit, R12 on-bits kept");
        cyc(200);
        expect_st(2'b10, 2'd1, 1'b0, "R9 watchdog disabled");

        // R11: supply loss hands the outputs to the direct pins
        supply_ok = 1'b0;
        direct_in = 2'b01;
        cyc(3);
        expect_st(2'b01, 2'd0, 1'b0, "R11 direct ch0");
        direct_in = 2'b10;
        cyc(1);
        expect_st(2'b10, 2'd0, 1'b0, "R11 direct ch1");
        direct_in = 2'b00;
        supply_ok = 1'b1;
        wd_bit    = 1'b0;
        cyc(4);
        expect_st(2'b00, 2'd1, 1'b0, "R11 settings cleared");
        check_val(ocp_high, 2, "R10 no extra reload");

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule